// File: doc/BRIEF.md
# PC Card Byte-Lane Access Sequencer

This block sits between an internal host port and a PC Card socket. The host presents one request at a time: a 32-bit word with four byte enables, a word address, a direction and an address space (common memory, attribute memory or I/O). The sequencer breaks the request into half-word or single-byte socket cycles. For each one it drives the two active-low card enables and address bit 0, pulses the strobe that belongs to the space and direction, and places write data on the correct lanes of the 16-bit data bus.

Read cycles always move a full half-word over both lanes. The bytes the host asked for are gathered into a 32-bit result, and every other byte reads as zero. Attribute memory holds data in its even bytes only, so odd attribute bytes are never written and always read back as zero. Write bytes whose enable is off cause no socket activity at all. A one-clock done pulse ends every request, including one that needed no bus cycle.

Top module: `pccard_lane_seq`

## Requirements
- R1: While reset is high and right after it, req_ready is 1, done is 0, both card enables and all four strobes are high, and md_oe is 0.
- R2: A common-memory or I/O write with both bytes of a half-word enabled makes one cycle with ce2_n=0, ce1_n=0 and address bit 0 = 0. The odd byte is on md_out[15:8] and the even byte on md_out[7:0].
- R3: A common-memory or I/O write with only one byte of a half-word enabled makes one cycle with ce2_n=1 and ce1_n=0, and the byte is placed on md_out[7:0] with md_out[15:8]=0. Address bit 0 is 0 for the even byte and 1 for the odd byte.
- R4: A write half-word with no enabled byte makes no socket cycle. A write with all enables off makes no cycle but still ends with a done pulse.
- R5: Each read cycle uses ce2_n=0, ce1_n=0 and address bit 0 = 0. A read fetches each half-word that holds an enabled byte, and fetches the lower half-word when no enable is on. The even byte comes from md_in[7:0] and the odd byte from md_in[15:8]. Bytes that were not requested return zero in rdata.
- R6: Space code 1 is attribute memory. A write there makes one even-byte cycle (ce2_n=1, ce1_n=0, bit 0 = 0, byte on md_out[7:0]) for each half-word whose even byte is enabled, and odd bytes make no cycle. A read returns only the even bytes, and the odd bytes read as zero.
- R7: Space code 2 is I/O. It uses ior_n for reads and iow_n for writes, with oe_n and we_n held high. Codes 0, 1 and 3 are memory and use oe_n and we_n, with the I/O strobes held high. At most one strobe is low at any time.
- R8: Half-words are issued lower address first. The card address is {req_waddr, h, a0}, where h is 0 for the lower half-word and 1 for the upper, so the address of the second cycle is 2 higher.
- R9: Each cycle asserts the enables and address for one clock with all strobes high. The strobe is then low for exactly STRB_CLKS clocks, and after that comes one clock with the enables and strobes all high.
- R10: req_ready is high only when idle, and a request is taken on req_valid && req_ready. After the last cycle, done is high for exactly one clock with rdata valid, and req_ready returns on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request can be taken |
| req_waddr | input | AW-2 | Word address of the request |
| req_be | input | 4 | Byte enables, bit n for byte n |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 common, 1 attribute, 2 I/O, 3 common |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Gathered read data, valid with done |
| card_addr | output | AW | Socket byte address |
| ce2_n | output | 1 | Card enable for the high lane, active low |
| ce1_n | output | 1 | Card enable for the low lane, active low |
| oe_n | output | 1 | Memory read strobe |
| we_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| md_out | output | 16 | Socket write data |
| md_oe | output | 1 | Data bus drive enable |
| md_in | input | 16 | Socket read data |

## Verification
Some requests produce an odd mix of cycles. A write may enable only the upper half-word, which skips the lower cycle and starts at the higher address. A read may have no enable set at all. An attribute write may enable only odd bytes and so make no cycle. Random byte enables reach these only now and then, so the bench adds directed requests for each of them. It then runs several hundred random requests in all spaces and directions. A bench socket model answers reads with a byte value computed from the address. A bus monitor records every strobe window, and the bench compares the recorded cycles with a list built from the rules above.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam logic [1:0] SP_COMMON = 2'd0;
    localparam logic [1:0] SP_ATTR   = 2'd1;
    localparam logic [1:0] SP_IO     = 2'd2;

    typedef struct packed {
        logic        write;
        logic [1:0]  space;
        logic [3:0]  be;
        logic [31:0] wdata;
    } pcc_req_t;

    typedef struct packed {
        logic        ce2_n;
        logic        ce1_n;
        logic        a0;
        logic [15:0] md;
    } lane_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_GAP,
        ST_DONE
    } seq_st_e;

    function automatic logic is_io(input logic [1:0] sp);
        return sp == SP_IO;
    endfunction

    // Whether half-word h of a request needs a socket cycle
    function automatic logic half_needed(input pcc_req_t r, input logic h);
        logic [1:0] b2;
        b2 = h ? r.be[3:2] : r.be[1:0];
        if (r.write) begin
            if (r.space == SP_ATTR) return b2[0];
            return |b2;
        end
        return (|b2) || (!h && (r.be == 4'b0000));
    endfunction

    // Enables, bit 0 and data lanes for half-word h
    function automatic lane_cfg_t lane_for(input pcc_req_t r, input logic h);
        lane_cfg_t  c;
        logic [1:0] b2;
        logic [15:0] w16;
        b2  = h ? r.be[3:2] : r.be[1:0];
        w16 = h ? r.wdata[31:16] : r.wdata[15:0];
        c.ce2_n = 1'b0;
        c.ce1_n = 1'b0;
        c.a0    = 1'b0;
        c.md    = 16'h0000;
        if (r.write) begin
            if (r.space == SP_ATTR) begin
                c.ce2_n = 1'b1;
                c.md    = {8'h00, w16[7:0]};
            end else if (b2 == 2'b01) begin
                c.ce2_n = 1'b1;
                c.md    = {8'h00, w16[7:0]};
            end else if (b2 == 2'b10) begin
                c.ce2_n = 1'b1;
                c.a0    = 1'b1;
                c.md    = {8'h00, w16[15:8]};
            end else begin
                c.md    = w16;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/pcc_plan.sv
module pcc_plan
    import pcc_pkg::*;
(
    input  pcc_req_t   req,
    output logic [1:0] need
);
    for (genvar g = 0; g < 2; g++) begin : g_half
        assign need[g] = half_needed(req, 1'(g));
    end
endmodule

// File: rtl/pcc_lane_mux.sv
module pcc_lane_mux
    import pcc_pkg::*;
(
    input  pcc_req_t  req,
    input  logic      cur_h,
    output lane_cfg_t cfg
);
    lane_cfg_t cand [2];

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign cand[g] = lane_for(req, 1'(g));
    end

    assign cfg = cur_h ? cand[1] : cand[0];
endmodule

// File: rtl/pcc_seq_fsm.sv
module pcc_seq_fsm
    import pcc_pkg::*;
#(
    parameter int STRB_CLKS = 3
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] need_in,
    output logic       req_ready,
    output logic       accept,
    output seq_st_e    state,
    output logic       cur_h,
    output logic       capture,
    output logic       done
);
    localparam int CW = $clog2(STRB_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STRB_CLKS - 1);

    logic [1:0]    pending;
    logic [CW-1:0] cnt;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state == ST_STROBE) && (cnt == LAST);
    assign done      = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pending <= 2'b00;
            cur_h   <= 1'b0;
            cnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        pending <= need_in;
                        cur_h   <= !need_in[0];
                        state   <= (need_in == 2'b00) ? ST_DONE : ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt   <= '0;
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (cnt == LAST) begin
                        pending[cur_h] <= 1'b0;
                        state          <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (pending != 2'b00) begin
                        cur_h <= pending[1];
                        state <= ST_SETUP;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pcc_rd_gather.sv
module pcc_rd_gather
    import pcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        capture,
    input  pcc_req_t    req,
    input  logic        cur_h,
    input  logic [15:0] md_in,
    output logic [31:0] rdata
);
    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [15:0] q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                q <= '0;
            end else if (capture && !req.write && (cur_h == 1'(g))) begin
                if (req.be[2*g])
                    q[7:0] <= md_in[7:0];
                if (req.be[2*g+1] && (req.space != SP_ATTR))
                    q[15:8] <= md_in[15:8];
            end
        end
        assign rdata[16*g +: 16] = q;
    end
endmodule

// File: rtl/pccard_lane_seq.sv
module pccard_lane_seq
    import pcc_pkg::*;
#(
    parameter int AW        = 26,
    parameter int STRB_CLKS = 3
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-3:0] req_waddr,
    input  logic [3:0]    req_be,
    input  logic          req_write,
    input  logic [1:0]    req_space,
    input  logic [31:0]   req_wdata,
    output logic          done,
    output logic [31:0]   rdata,
    output logic [AW-1:0] card_addr,
    output logic          ce2_n,
    output logic          ce1_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          ior_n,
    output logic          iow_n,
    output logic [15:0]   md_out,
    output logic          md_oe,
    input  logic [15:0]   md_in
);
    pcc_req_t      in_req;
    pcc_req_t      req_q;
    logic [AW-3:0] waddr_q;
    logic [1:0]    need;
    logic          accept;
    logic          cur_h;
    logic          capture;
    seq_st_e       state;
    lane_cfg_t     cfg;
    logic          active;
    logic          strobe_on;
    logic          io_sp;

    assign in_req = '{write: req_write, space: req_space, be: req_be, wdata: req_wdata};

    pcc_plan u_plan (
        .req  (in_req),
        .need (need)
    );

    pcc_seq_fsm #(.STRB_CLKS(STRB_CLKS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .need_in   (need),
        .req_ready (req_ready),
        .accept    (accept),
        .state     (state),
        .cur_h     (cur_h),
        .capture   (capture),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            waddr_q <= '0;
        end else if (accept) begin
            req_q   <= in_req;
            waddr_q <= req_waddr;
        end
    end

    pcc_lane_mux u_lane (
        .req   (req_q),
        .cur_h (cur_h),
        .cfg   (cfg)
    );

    pcc_rd_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .capture (capture),
        .req     (req_q),
        .cur_h   (cur_h),
        .md_in   (md_in),
        .rdata   (rdata)
    );

    assign active    = (state == ST_SETUP) || (state == ST_STROBE);
    assign strobe_on = (state == ST_STROBE);
    assign io_sp     = is_io(req_q.space);

    assign ce2_n     = active ? cfg.ce2_n : 1'b1;
    assign ce1_n     = active ? cfg.ce1_n : 1'b1;
    assign card_addr = active ? {waddr_q, cur_h, cfg.a0} : '0;

    assign oe_n  = !(strobe_on && !req_q.write && !io_sp);
    assign we_n  = !(strobe_on &&  req_q.write && !io_sp);
    assign ior_n = !(strobe_on && !req_q.write &&  io_sp);
    assign iow_n = !(strobe_on &&  req_q.write &&  io_sp);

    assign md_oe  = active && req_q.write;
    assign md_out = md_oe ? cfg.md : 16'h0000;
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk #(
    parameter int STRB_CLKS = 3
)(
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        done,
    input logic        ce2_n,
    input logic        ce1_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        ior_n,
    input logic        iow_n,
    input logic [15:0] md_out
);
    localparam int LW = $clog2(STRB_CLKS + 2) + 1;

    logic [3:0]    strb_n;
    logic          any_strb;
    logic [LW-1:0] low_cnt;

    assign strb_n   = {oe_n, we_n, ior_n, iow_n};
    assign any_strb = !(&strb_n);

    always_ff @(posedge clk) begin
        if (rst)           low_cnt <= '0;
        else if (any_strb) low_cnt <= low_cnt + 1'b1;
        else               low_cnt <= '0;
    end

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~strb_n) <= 1);

    // R7
    strobe_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        any_strb |-> !ce1_n);

    // R10
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&strb_n && ce1_n && ce2_n));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(any_strb) |-> ($past(!ce1_n) && $past(&strb_n)));

    // R9
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(any_strb) |-> (low_cnt == LW'(STRB_CLKS)));

    // R9
    strobe_bound_chk: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LW'(STRB_CLKS));

    // R3
    single_byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
        ((!we_n || !iow_n) && ce2_n) |-> (md_out[15:8] == 8'h00));
endmodule

bind pccard_lane_seq pcc_chk #(.STRB_CLKS(STRB_CLKS)) u_pcc_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .done      (done),
    .ce2_n     (ce2_n),
    .ce1_n     (ce1_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .md_out    (md_out)
);

// File: tb/tb_pccard_lane_seq.sv
`timescale 1ns/1ps
module tb_pccard_lane_seq;
    localparam int AW = 26;
    localparam int SC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-3:0] req_waddr = '0;
    logic [3:0]    req_be = '0;
    logic          req_write = 1'b0;
    logic [1:0]    req_space = '0;
    logic [31:0]   req_wdata = '0;
    logic          done;
    logic [31:0]   rdata;
    logic [AW-1:0] card_addr;
    logic          ce2_n, ce1_n, oe_n, we_n, ior_n, iow_n;
    logic [15:0]   md_out;
    logic          md_oe;
    logic [15:0]   md_in;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pccard_lane_seq #(.AW(AW), .STRB_CLKS(SC)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_waddr(req_waddr), .req_be(req_be), .req_write(req_write),
        .req_space(req_space), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .card_addr(card_addr), .ce2_n(ce2_n), .ce1_n(ce1_n), .oe_n(oe_n),
        .we_n(we_n), .ior_n(ior_n), .iow_n(iow_n), .md_out(md_out),
        .md_oe(md_oe), .md_in(md_in)
    );

    // socket model: byte value derived from its address
    function automatic logic [7:0] cb(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5 ^ {a[0], 7'h00};
    endfunction

    assign md_in = {cb(card_addr | AW'(1)), cb(card_addr & ~AW'(1))};

    // bus monitor
    int          ev_n = 0;
    logic [1:0]  ev_kind [8];
    logic        ev_ce2  [8];
    logic        ev_ce1  [8];
    logic [AW-1:0] ev_addr [8];
    logic [15:0] ev_md   [8];
    int          ev_w    [8];
    logic        ev_setup[8];
    logic        ev_gap  [8];
    logic        prev_low = 1'b0;
    logic        prev_setup = 1'b0;
    int          wcnt = 0;

    always @(negedge clk) begin
        logic low;
        low = !(oe_n && we_n && ior_n && iow_n);
        if (!rst && ev_n < 8) begin
            if (low && !prev_low) begin
                ev_kind[ev_n]  = !we_n ? 2'd1 : (!ior_n ? 2'd2 : (!iow_n ? 2'd3 : 2'd0));
                ev_ce2[ev_n]   = ce2_n;
                ev_ce1[ev_n]   = ce1_n;
                ev_addr[ev_n]  = card_addr;
                ev_md[ev_n]    = md_out;
                ev_setup[ev_n] = prev_setup;
                wcnt = 1;
            end else if (low) begin
                wcnt++;
            end
            if (!low && prev_low) begin
                ev_w[ev_n]   = wcnt;
                ev_gap[ev_n] = ce1_n && ce2_n;
                ev_n++;
            end
        end
        prev_low   = low;
        prev_setup = !ce1_n && !low;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // expected cycle list
    int          x_n;
    logic [1:0]  x_kind [8];
    logic        x_ce2  [8];
    logic [AW-1:0] x_addr [8];
    logic [15:0] x_md   [8];
    string       x_tag  [8];
    logic [31:0] x_rd;

    task automatic add_exp(input logic [1:0] k, input logic c2, input logic [AW-1:0] a,
                           input logic [15:0] m, input string t);
        x_kind[x_n] = k; x_ce2[x_n] = c2; x_addr[x_n] = a; x_md[x_n] = m; x_tag[x_n] = t;
        x_n++;
    endtask

    task automatic build_exp(input logic [AW-3:0] wa, input logic [3:0] be, input logic wr,
                             input logic [1:0] sp, input logic [31:0] wd);
        x_n = 0;
        x_rd = 32'h0;
        for (int h = 0; h < 2; h++) begin
            logic [1:0]  b2;
            logic [15:0] w16;
            logic [AW-1:0] base;
            logic [1:0]  k;
            b2   = be[2*h +: 2];
            w16  = wd[16*h +: 16];
            base = {wa, h[0], 1'b0};
            k    = wr ? ((sp == 2'd2) ? 2'd3 : 2'd1) : ((sp == 2'd2) ? 2'd2 : 2'd0);
            if (wr) begin
                if (sp == 2'd1) begin
                    if (b2[0]) add_exp(k, 1'b1, base, {8'h00, w16[7:0]}, "R6");
                end else if (b2 == 2'b11) add_exp(k, 1'b0, base, w16, "R2");
                else if (b2 == 2'b01) add_exp(k, 1'b1, base, {8'h00, w16[7:0]}, "R3");
                else if (b2 == 2'b10) add_exp(k, 1'b1, base | AW'(1), {8'h00, w16[15:8]}, "R3");
            end else begin
                if ((|b2) || (be == 4'b0000 && h == 0))
                    add_exp(k, 1'b0, base, 16'h0000, "R5");
                if (b2[0]) x_rd[16*h +: 8] = cb(base);
                if (b2[1] && sp != 2'd1) x_rd[16*h+8 +: 8] = cb(base | AW'(1));
            end
        end
    endtask

    task automatic run_req(input logic [AW-3:0] wa, input logic [3:0] be, input logic wr,
                           input logic [1:0] sp, input logic [31:0] wd);
        int  n;
        bit  seen;
        build_exp(wa, be, wr, sp, wd);
        @(negedge clk);
        chk(req_ready === 1'b1, "R10 ready idle", {63'h0, req_ready}, 64'h1);
        ev_n = 0;
        req_valid = 1'b1; req_waddr = wa; req_be = be; req_write = wr;
        req_space = sp; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0, "R10 busy", {63'h0, req_ready}, 64'h0);
        seen = 0;
        for (int t = 0; t < 60 && !seen; t++) begin
            if (done === 1'b1) seen = 1;
            else @(negedge clk);
        end
        chk(seen, "R10 done seen", {63'h0, seen}, 64'h1);
        n = ev_n;
        chk(n == x_n, (wr && x_n < 2) ? "R4 cycle count" : "R5 cycle count", 64'(n), 64'(x_n));
        for (int i = 0; i < x_n && i < n; i++) begin
            chk(ev_kind[i] == x_kind[i], "R7 strobe", 64'(ev_kind[i]), 64'(x_kind[i]));
            chk(ev_ce2[i] == x_ce2[i] && ev_ce1[i] == 1'b0 && ev_md[i] == x_md[i], x_tag[i],
                {31'h0, ev_ce2[i], ev_ce1[i], ev_md[i], 15'h0}, {31'h0, x_ce2[i], 1'b0, x_md[i], 15'h0});
            chk(ev_addr[i] == x_addr[i], "R8 address", 64'(ev_addr[i]), 64'(x_addr[i]));
            chk(ev_w[i] == SC && ev_setup[i] && ev_gap[i], "R9 timing",
                {ev_setup[i], ev_gap[i], 62'(ev_w[i])}, {2'b11, 62'(SC)});
        end
        chk(rdata == x_rd, wr ? "R4 rdata" : (sp == 2'd1 ? "R6 rdata" : "R5 rdata"),
            64'(rdata), 64'(x_rd));
        @(negedge clk);
        chk(done === 1'b0 && req_ready === 1'b1, "R10 pulse", {62'h0, done, req_ready}, 64'h1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready && !done && ce1_n && ce2_n && oe_n && we_n && ior_n && iow_n && !md_oe,
            "R1 in reset", {56'h0, req_ready, done, ce1_n, ce2_n, oe_n, we_n, ior_n, iow_n}, 64'hBF);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !done && ce1_n && ce2_n && oe_n && we_n && ior_n && iow_n && !md_oe,
            "R1 after reset", {56'h0, req_ready, done, ce1_n, ce2_n, oe_n, we_n, ior_n, iow_n}, 64'hBF);

        run_req(24'h000100, 4'b1111, 1'b1, 2'd0, 32'hA1B2_C3D4);   // R2 R8
        run_req(24'h000101, 4'b0001, 1'b1, 2'd0, 32'h1122_3344);   // R3 even
        run_req(24'h000102, 4'b0010, 1'b1, 2'd2, 32'h1122_3344);   // R3 odd, R7 io
        run_req(24'h000103, 4'b0000, 1'b1, 2'd0, 32'hFFFF_FFFF);   // R4 no cycle
        run_req(24'h000104, 4'b1100, 1'b1, 2'd0, 32'h5566_7788);   // R4 skip lower, R8
        run_req(24'h000105, 4'b0110, 1'b1, 2'd2, 32'hCAFE_BEEF);   // R3 twice
        run_req(24'h000106, 4'b1111, 1'b1, 2'd1, 32'h0102_0304);   // R6 even only
        run_req(24'h000107, 4'b1010, 1'b1, 2'd1, 32'hDEAD_BEEF);   // R6 odd only: none
        run_req(24'h000108, 4'b0000, 1'b0, 2'd0, 32'h0);           // R5 empty read
        run_req(24'h000109, 4'b1000, 1'b0, 2'd0, 32'h0);           // R5 upper byte
        run_req(24'h00010A, 4'b1111, 1'b0, 2'd1, 32'h0);           // R6 attr read
        run_req(24'h00010B, 4'b0101, 1'b0, 2'd2, 32'h0);           // R5 R7 io read
        run_req(24'h00010C, 4'b1111, 1'b1, 2'd3, 32'h9988_7766);   // R7 code 3

        for (int i = 0; i < 400; i++) begin
            run_req(24'($urandom), 4'($urandom), 1'($urandom), 2'($urandom), $urandom);
        end
        finish_run();
    end
endmodule